// File: doc/BRIEF.md
# Boot-Window Watchdog with Refresh Flag

This block is a watchdog timer whose window counter starts at zero when the system leaves reset and runs whether or not the watchdog is armed. Every `WINDOW_CYCLES` clock cycles a window closes. When the watchdog is armed and software has not set the refresh flag during that window, the block raises a reset request for `PULSE_CYCLES` cycles. The system reset controller consumes that request. When the refresh flag is set, the block clears it and another window begins.

Software reaches the block through a single write strobe that carries two data bits. One bit arms the watchdog, and once set it stays set until the next reset. The other bit sets the refresh flag, which software can read back. A write of 0 to either bit does nothing. The counter runs from reset, so arming late can shorten the first window. If a window has already closed while the watchdog was unarmed and no refresh was written since, the block remembers that closure. Arming without a refresh in the same write then requests a reset at once.

No data stream passes through this block, so every pin is plain control or status and no valid/ready handshake applies.

Top module: `boot_window_wdog`

## Requirements
- R1: While `rst_n` is low and just after it rises, `wdg_rst_o` and `refresh_o` are 0 and the window counter is at zero.
- R2: The window counter runs whether or not the watchdog is armed. Counting the rising edges after `rst_n` goes high as 1, 2, 3, windows close at edges `WINDOW_CYCLES`, 2·`WINDOW_CYCLES`, and so on.
- R3: If a window closes while the watchdog is armed and the refresh flag is 0, `wdg_rst_o` is high from that closing edge for exactly `PULSE_CYCLES` cycles. A request that arrives while a pulse is already running is dropped.
- R4: A write with `cfg_wr_i`=1 and `cfg_refresh_i`=1 sets `refresh_o` at the next edge. Hardware clears `refresh_o` at every window close. If the flag is set when an armed window closes, no pulse is issued.
- R5: A write with `cfg_enable_i`=1 arms the watchdog. A write with `cfg_enable_i`=0 neither arms it nor disarms it; only reset disarms it.
- R6: While the watchdog is unarmed, no pulse is issued. A window that closes with the refresh flag 0 while the watchdog is unarmed is remembered as elapsed.
- R7: Arming the watchdog while an elapsed closure is remembered issues a pulse starting at the edge that takes the write, unless the refresh flag is 1 or the same write sets it.
- R8: Any write that sets the refresh flag clears the elapsed record. Setting the refresh flag before arming, or in the same write as arming, therefore guarantees no pulse at the next window close.
- R9: A refresh write taken at the same edge as a window close counts for the window that is closing, so no pulse is issued. After that edge `refresh_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| cfg_wr_i | input | 1 | Register write strobe, one cycle per write |
| cfg_enable_i | input | 1 | Write data: 1 arms the watchdog |
| cfg_refresh_i | input | 1 | Write data: 1 sets the refresh flag |
| refresh_o | output | 1 | Readable refresh flag |
| wdg_rst_o | output | 1 | Reset request pulse |

## Verification
Two events can land in the same cycle: a software refresh write and the hardware window close. Both touch the refresh flag, and both take part in the decision to fire. The bench times a refresh write so that the edge taking the write is also the edge that closes an armed window. It then checks that no pulse starts at that edge, that `refresh_o` reads 0 afterwards, and that the following window, which has no refresh, does fire. A second overlap, arming in the same write as a refresh while an elapsed closure is remembered, is checked as well: it must issue no immediate pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // One register write as seen by the watchdog: data bits qualified by the strobe.
  typedef struct packed {
    logic arm;
    logic refresh;
  } wdg_wr_t;

  function automatic wdg_wr_t wdg_decode(input logic stb, input logic en_bit, input logic rf_bit);
    wdg_wr_t w;
    w.arm     = stb & en_bit;
    w.refresh = stb & rf_bit;
    return w;
  endfunction
endpackage

// File: rtl/wdg_window_ctr.sv
module wdg_window_ctr #(
  parameter int WINDOW_CYCLES = 16000
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  localparam int CW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign win_end = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (win_end) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wdg_wr_t wr,
  input  logic    win_end,
  output logic    armed_q,
  output logic    refresh_q,
  output logic    fire
);
  logic elapsed_q;
  logic armed_eff, refresh_eff;
  logic fire_window, fire_late;
  logic elapsed_d;

  // A write landing in the closing cycle counts for that window.
  assign armed_eff   = armed_q | wr.arm;
  assign refresh_eff = refresh_q | wr.refresh;

  assign fire_window = win_end & armed_eff & ~refresh_eff;
  assign fire_late   = wr.arm & ~armed_q & elapsed_q & ~refresh_eff;
  assign fire        = fire_window | fire_late;

  always_comb begin
    elapsed_d = elapsed_q;
    if (wr.refresh)                              elapsed_d = 1'b0;
    else if (win_end & ~armed_eff & ~refresh_q)  elapsed_d = 1'b1;
    else if (wr.arm)                             elapsed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      refresh_q <= 1'b0;
      elapsed_q <= 1'b0;
    end else begin
      armed_q   <= armed_eff;
      refresh_q <= win_end ? 1'b0 : refresh_eff;
      elapsed_q <= elapsed_d;
    end
  end
endmodule

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
  parameter int PULSE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
    else if (fire)            left_q <= PW'(PULSE_CYCLES);
  end
endmodule

// File: rtl/boot_window_wdog.sv
module boot_window_wdog
  import wdg_pkg::*;
#(
  parameter int WINDOW_CYCLES = 16000,
  parameter int PULSE_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr_i,
  input  logic cfg_enable_i,
  input  logic cfg_refresh_i,
  output logic refresh_o,
  output logic wdg_rst_o
);
  wdg_wr_t wr;
  logic    win_end;
  logic    en_state;
  logic    fire;

  assign wr = wdg_decode(cfg_wr_i, cfg_enable_i, cfg_refresh_i);

  wdg_window_ctr #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_end (win_end)
  );

  wdg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr),
    .win_end   (win_end),
    .armed_q   (en_state),
    .refresh_q (refresh_o),
    .fire      (fire)
  );

  wdg_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .pulse_o (wdg_rst_o)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int PULSE_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr_i,
  input logic cfg_enable_i,
  input logic cfg_refresh_i,
  input logic refresh_o,
  input logic wdg_rst_o,
  input logic en_state,
  input logic win_end
);
  localparam int LW = $clog2(PULSE_CYCLES + 2);
  logic [LW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               hi_len <= '0;
    else if (!wdg_rst_o)                      hi_len <= '0;
    else if (hi_len != LW'(PULSE_CYCLES + 1)) hi_len <= hi_len + 1'b1;
  end

  a_r3_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= LW'(PULSE_CYCLES));
  a_r3_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_rst_o) |=> wdg_rst_o);
  a_r4_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_o) |-> $past(cfg_wr_i && cfg_refresh_i));
  a_r9_clear_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !refresh_o);
  a_r5_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_state |=> en_state);
  a_r6_no_fire_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_rst_o) |-> ($past(en_state) || $past(cfg_wr_i && cfg_enable_i)));
endmodule

bind boot_window_wdog wdg_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_wdg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_enable_i  (cfg_enable_i),
  .cfg_refresh_i (cfg_refresh_i),
  .refresh_o     (refresh_o),
  .wdg_rst_o     (wdg_rst_o),
  .en_state      (en_state),
  .win_end       (win_end)
);

// File: tb/test_boot_window_wdog.sv
`timescale 1ns/1ps
module test_boot_window_wdog;
  localparam int W = 50;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_i = 1'b0, cfg_enable_i = 1'b0, cfg_refresh_i = 1'b0;
  logic refresh_o, wdg_rst_o;

  always #2.5 clk = ~clk;

  boot_window_wdog #(.WINDOW_CYCLES(W), .PULSE_CYCLES(P)) i_boot_window_wdog (
    .clk (clk), .rst_n (rst_n), .cfg_wr_i (cfg_wr_i), .cfg_enable_i (cfg_enable_i),
    .cfg_refresh_i (cfg_refresh_i), .refresh_o (refresh_o), .wdg_rst_o (wdg_rst_o)
  );

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct { int at; string tag; } exp_t;
  exp_t exp_q[$];
  int n_run = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Monitor: pops the expected pulse starts and compares them with what the design does.
  logic prev = 1'b0;
  int   width = 0;
  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      prev  <= 1'b0;
      width <= 0;
    end else begin
      if (wdg_rst_o && !prev) begin
        if (exp_q.size() == 0) check(1'b0, "R6", cyc, -1, "unexpected pulse start");
        else begin
          e = exp_q.pop_front();
          check(cyc == e.at, e.tag, cyc, e.at, "pulse start cycle");
        end
      end
      if (!wdg_rst_o && prev) check(width == P, "R3", width, P, "pulse width");
      width <= wdg_rst_o ? width + 1 : 0;
      prev  <= wdg_rst_o;
    end
  end

  task automatic expect_fire(input int at, input string tag);
    exp_t e;
    e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Drive one write so that it is taken at edge number 'at'.
  task automatic wr(input int at, input logic en, input logic rf);
    wait_to(at - 1);
    cfg_wr_i = 1'b1; cfg_enable_i = en; cfg_refresh_i = rf;
    @(negedge clk);
    cfg_wr_i = 1'b0; cfg_enable_i = 1'b0; cfg_refresh_i = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic end_scn(input int n);
    wait_to(n);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0, "expected pulses still pending");
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired: got %0d expected finish", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state; R6 unarmed never fires across three windows
    repeat (2) @(negedge clk);
    check(wdg_rst_o == 1'b0, "R1", wdg_rst_o, 0, "request during reset");
    check(refresh_o == 1'b0, "R1", refresh_o, 0, "refresh during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(wdg_rst_o == 1'b0, "R1", wdg_rst_o, 0, "request after reset");
    end_scn(3 * W + 5);
    check(refresh_o == 1'b0, "R6", refresh_o, 0, "refresh idle");

    // R2/R3: armed early, no refresh: fires at every close
    apply_reset();
    expect_fire(W, "R3");
    expect_fire(2 * W, "R2");
    wr(2, 1'b1, 1'b0);
    wait_to(W + 2);
    check(wdg_rst_o == 1'b1, "R3", wdg_rst_o, 1, "pulse active");
    end_scn(2 * W + P + 3);

    // R4: refresh then arm; flag read back, cleared at close, saves one window
    apply_reset();
    expect_fire(2 * W, "R4");
    wr(10, 1'b0, 1'b1);
    wr(11, 1'b1, 1'b0);
    wait_to(12);
    check(refresh_o == 1'b1, "R4", refresh_o, 1, "refresh readback");
    wait_to(W + 1);
    check(refresh_o == 1'b0, "R4", refresh_o, 0, "hardware clear");
    end_scn(2 * W + P + 3);

    // R7: late arm after an elapsed window fires at once
    apply_reset();
    wait_to(W + 5);
    check(wdg_rst_o == 1'b0, "R6", wdg_rst_o, 0, "unarmed close");
    expect_fire(W + 10, "R7");
    expect_fire(2 * W, "R2");
    wr(W + 10, 1'b1, 1'b0);
    end_scn(2 * W + P + 3);

    // R2: arming inside first window gives a shortened window
    apply_reset();
    expect_fire(W, "R2");
    wr(30, 1'b1, 1'b0);
    end_scn(W + P + 3);

    // R8: refresh before arming clears elapsed and saves a full window
    apply_reset();
    expect_fire(3 * W, "R8");
    wr(W + 5, 1'b0, 1'b1);
    wr(W + 10, 1'b1, 1'b0);
    wait_to(W + 12);
    check(wdg_rst_o == 1'b0, "R8", wdg_rst_o, 0, "no immediate pulse");
    end_scn(3 * W + P + 3);

    // R5: zero writes neither arm nor disarm
    apply_reset();
    wr(5, 1'b0, 1'b0);
    wr(6, 1'b0, 1'b0);
    wait_to(2 * W + 2);
    check(wdg_rst_o == 1'b0, "R5", wdg_rst_o, 0, "zero write did not arm");
    expect_fire(2 * W + 5, "R7");
    expect_fire(3 * W, "R5");
    wr(2 * W + 5, 1'b1, 1'b0);
    wr(2 * W + 20, 1'b0, 1'b0);
    end_scn(3 * W + P + 3);

    // R9: refresh taken at the closing edge counts for that window
    apply_reset();
    expect_fire(W, "R3");
    expect_fire(3 * W, "R9");
    wr(2, 1'b1, 1'b0);
    wr(2 * W, 1'b0, 1'b1);
    wait_to(2 * W + 1);
    check(refresh_o == 1'b0, "R9", refresh_o, 0, "flag after coincident close");
    check(wdg_rst_o == 1'b0, "R9", wdg_rst_o, 0, "no pulse at coincident close");
    end_scn(3 * W + P + 3);

    // R8: arm and refresh in one write while elapsed
    apply_reset();
    expect_fire(3 * W, "R8");
    wr(W + 10, 1'b1, 1'b1);
    wait_to(W + 11);
    check(refresh_o == 1'b1, "R8", refresh_o, 1, "combined write flag");
    check(wdg_rst_o == 1'b0, "R8", wdg_rst_o, 0, "combined write no pulse");
    wait_to(2 * W + 1);
    check(refresh_o == 1'b0, "R4", refresh_o, 0, "cleared at close");
    end_scn(3 * W + P + 3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule